// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Masked Interrupts

This block buffers 16-bit audio samples between a processor or DMA engine and a serial audio shifter. It holds two queues. The transmit queue is filled through a word-wide register port and drained by the shifter. The receive queue is filled by the shifter and drained through the register port. Each queue reports its fill count and four level flags. Two of those flags, almost-empty and almost-full, are placed by a programmable 6-bit level, so software or a DMA engine can be woken before the queue runs dry or overflows.

The shifter side cannot be stalled, because it runs at the audio frame rate. Each direction therefore has a valid/ready-style pair, but back-pressure is advisory. `tx_ser_valid` says a sample is waiting. `rx_ser_ready` says there is room. A take strobe while nothing is valid is recorded as a starve error and returns nothing. A put strobe while not ready is recorded as an overflow error and the sample is dropped. The register side has the same two errors: reading an empty receive queue is a starve, and writing a full transmit queue is an overflow.

The thirteen sources are the four flags and two errors of each queue, plus a word-moved event on the shifter side. They feed a latched, individually enabled interrupt unit with a global enable. Each queue also drives a DMA request, gated by that direction's DMA enable.

Top module: `afi_audio_fifo`

## Requirements
- R1: Register select codes on `reg_addr` are:
  - 0: control
  - 1: interrupt enable
  - 2: interrupt status
  - 3: queue status
  - 4: transmit data (write)
  - 5: receive data (read)
  - 6: interrupt clear (write)

  A read returns its value in `reg_rdata` on the cycle after `reg_rd`. After reset, control, interrupt enable and interrupt status read 0, queue status reads 0x300C, and `irq`, both DMA requests and `tx_ser_valid` are low.
- R2: Control bit 0 enables the transmit queue. Accepted transmit words leave on `tx_ser_data` in write order, one per `tx_ser_take` strobe while `tx_ser_valid` is high. The queue holds 32 samples.
- R3: A write to the transmit data register is pushed only if bit 16 (the valid flag) is set; bits 15:0 carry the sample. A write with bit 16 clear leaves the queue unchanged.
- R4: Control bit 1 enables the receive queue. A receive data read returns the oldest sample in bits 15:0 with bit 16 set, and removes it from the queue. A read of an empty queue returns 0 and sets the receive starve source.
- R5: Queue status carries the transmit count in bits 19:14 and the receive count in bits 9:4. The transmit flags are in bits 13:10 and the receive flags in bits 3:0, each group ordered empty, almost-empty, full, almost-full from the high bit down. Almost-empty means count <= level. Almost-full means count + level >= 32. The transmit level is control bits 18:13 and the receive level is control bits 12:7.
- R6: A push into a full queue drops the sample and sets that queue's overflow source. `rx_ser_ready` is low while the receive queue is full.
- R7: A `tx_ser_take` while the transmit queue is empty returns nothing and sets the transmit starve source.
- R8: A disabled queue ignores pushes and pops. Its count is unchanged and it raises no starve or overflow source.
- R9: Interrupt enable bits 12:0 enable the sources, and bit 14 is the global enable. The sources are:
  - bit 12: word moved
  - bits 11..6, transmit: empty, almost-empty, full, almost-full, starve, overflow
  - bits 5..0, receive: the same six in the same order

  Interrupt status latches a source at its own bit position only while that source is enabled, and holds it. Status bit 13 is set while any bit is latched. `irq` equals that bit ANDed with the global enable.
- R10: Any write to the interrupt clear register empties the latched status. A level source that is still true and enabled is latched again on the following cycle.
- R11: `tx_dma_req` is high while control bit 2 (transmit DMA enable) and the transmit enable are set and the transmit queue is almost empty. `rx_dma_req` is high while control bit 3 (receive DMA enable) and the receive enable are set and the receive queue is almost full.
- R12: The word-moved source fires on every sample accepted from `rx_ser_put` and every sample handed out on `tx_ser_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tx_ser_data | output | 16 | Oldest transmit sample |
| tx_ser_valid | output | 1 | Transmit sample available |
| tx_ser_take | input | 1 | Shifter consumes the transmit sample |
| rx_ser_data | input | 16 | Sample from the shifter |
| rx_ser_put | input | 1 | Shifter delivers a sample |
| rx_ser_ready | output | 1 | Receive queue has room |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the edges of the queue:
- It writes a 33rd sample and takes once more than was written. A design that wrapped its count or overwrote the head would return a wrong sample order after the overflow, or would miss the starve flag.
- It moves the count across the threshold by exactly one sample in each direction. A design with an off-by-one in the almost-empty or almost-full compare, or in the DMA request that follows them, would flip one count too early or too late.
- It disables both queues and strobes every path. A design that let a disabled queue move or report errors would show a count or status change.
- It clears the status while the empty level source is still enabled. A design that treated clear as a mask, or let clear lose to the set, would read a wrong value on one of the two following reads.

// File: rtl/afi_pkg.sv
package afi_pkg;

  // register select codes on the simple register port
  typedef enum logic [2:0] {
    REG_CTRL      = 3'd0,
    REG_IRQ_EN    = 3'd1,
    REG_IRQ_STAT  = 3'd2,
    REG_FIFO_STAT = 3'd3,
    REG_TX_DATA   = 3'd4,
    REG_RX_DATA   = 3'd5,
    REG_IRQ_CLR   = 3'd6
  } reg_sel_e;

  // level flags of one queue, high bit first in the status word
  typedef struct packed {
    logic empty;
    logic almost_empty;
    logic full;
    logic almost_full;
  } fifo_flags_t;

  localparam int SRC_N   = 13;
  localparam int GLB_BIT = 14;
  localparam int PND_BIT = 13;

endpackage

// File: rtl/afi_sample_fifo.sv
module afi_sample_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          push_done,
  output logic          pop_done,
  output logic          overflow,
  output logic          starve
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          is_full, is_empty;

  assign is_full   = (count == CW'(DEPTH));
  assign is_empty  = (count == '0);
  assign push_done = en & push_req & ~is_full;
  assign pop_done  = en & pop_req & ~is_empty;
  assign overflow  = en & push_req & is_full;
  assign starve    = en & pop_req & is_empty;
  assign head      = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_done) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_done) wr_ptr <= bump(wr_ptr);
      if (pop_done)  rd_ptr <= bump(rd_ptr);
      case ({push_done, pop_done})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));  // R6
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !pop_done) |=> (count == $past(count)));  // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == $past(count)));  // R8

endmodule

// File: rtl/afi_level_flags.sv
module afi_level_flags
  import afi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 6,
  parameter int LW    = 6,
  localparam int SW   = ((CW > LW) ? CW : LW) + 1
) (
  input  logic [CW-1:0] count,
  input  logic [LW-1:0] level,
  output fifo_flags_t   flags
);

  logic [SW-1:0] cnt_x, lvl_x, sum_x;

  assign cnt_x = SW'(count);
  assign lvl_x = SW'(level);
  assign sum_x = cnt_x + lvl_x;

  always_comb begin
    flags.empty        = (count == '0);
    flags.full         = (count == CW'(DEPTH));
    flags.almost_empty = (cnt_x <= lvl_x);
    flags.almost_full  = (sum_x >= SW'(DEPTH));
  end

  always_comb begin
    AST_FULL_IS_AFULL: assert (!flags.full || flags.almost_full);  // R5
    AST_EMPTY_IS_AEMPTY: assert (!flags.empty || flags.almost_empty);  // R5
  end

endmodule

// File: rtl/afi_irq_unit.sv
module afi_irq_unit #(
  parameter int SRC_N = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src,
  input  logic [SRC_N-1:0] src_en,
  input  logic             global_en,
  input  logic             clr,
  output logic [SRC_N-1:0] status,
  output logic             pending,
  output logic             irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status <= '0;
    else if (clr) status <= '0;
    else          status <= status | (src & src_en);
  end

  assign pending = |status;
  assign irq     = pending & global_en;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status & $past(status)) == $past(status)));  // R9
  AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status & ~$past(status) & ~$past(src & src_en)) == '0));  // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (status == '0));  // R10

endmodule

// File: rtl/afi_audio_fifo.sv
module afi_audio_fifo
  import afi_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 16,
  parameter int LEVEL_W  = 6,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int TXL_LSB = 13,
  localparam int RXL_LSB = 7,
  localparam int PAD_W   = 31 - SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [SAMPLE_W-1:0] tx_ser_data,
  output logic                tx_ser_valid,
  input  logic                tx_ser_take,
  input  logic [SAMPLE_W-1:0] rx_ser_data,
  input  logic                rx_ser_put,
  output logic                rx_ser_ready,
  output logic                tx_dma_req,
  output logic                rx_dma_req,
  output logic                irq
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  // control state
  logic               tx_en, rx_en, tx_dma_en, rx_dma_en;
  logic [LEVEL_W-1:0] tx_lvl, rx_lvl;
  logic [SRC_N-1:0]   src_en;
  logic               glb_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en     <= 1'b0;
      rx_en     <= 1'b0;
      tx_dma_en <= 1'b0;
      rx_dma_en <= 1'b0;
      tx_lvl    <= '0;
      rx_lvl    <= '0;
      src_en    <= '0;
      glb_en    <= 1'b0;
    end else if (reg_wr) begin
      if (sel == REG_CTRL) begin
        tx_en     <= reg_wdata[0];
        rx_en     <= reg_wdata[1];
        tx_dma_en <= reg_wdata[2];
        rx_dma_en <= reg_wdata[3];
        tx_lvl    <= reg_wdata[TXL_LSB +: LEVEL_W];
        rx_lvl    <= reg_wdata[RXL_LSB +: LEVEL_W];
      end
      if (sel == REG_IRQ_EN) begin
        src_en <= reg_wdata[SRC_N-1:0];
        glb_en <= reg_wdata[GLB_BIT];
      end
    end
  end

  // queue instances
  logic                tx_push, rx_pop, irq_clr;
  logic [SAMPLE_W-1:0] tx_head, rx_head;
  logic [CNT_W-1:0]    tx_cnt, rx_cnt;
  logic                tx_push_done, tx_pop_done, tx_ovf, tx_starve;
  logic                rx_push_done, rx_pop_done, rx_ovf, rx_starve;
  fifo_flags_t         tx_flags, rx_flags;

  assign tx_push = reg_wr && (sel == REG_TX_DATA) && reg_wdata[SAMPLE_W];
  assign rx_pop  = reg_rd && (sel == REG_RX_DATA);
  assign irq_clr = reg_wr && (sel == REG_IRQ_CLR);

  afi_sample_fifo #(.DEPTH(DEPTH), .DW(SAMPLE_W)) u_tx_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tx_en),
    .push_req  (tx_push),
    .push_data (reg_wdata[SAMPLE_W-1:0]),
    .pop_req   (tx_ser_take),
    .head      (tx_head),
    .count     (tx_cnt),
    .push_done (tx_push_done),
    .pop_done  (tx_pop_done),
    .overflow  (tx_ovf),
    .starve    (tx_starve)
  );

  afi_sample_fifo #(.DEPTH(DEPTH), .DW(SAMPLE_W)) u_rx_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .push_req  (rx_ser_put),
    .push_data (rx_ser_data),
    .pop_req   (rx_pop),
    .head      (rx_head),
    .count     (rx_cnt),
    .push_done (rx_push_done),
    .pop_done  (rx_pop_done),
    .overflow  (rx_ovf),
    .starve    (rx_starve)
  );

  afi_level_flags #(.DEPTH(DEPTH), .CW(CNT_W), .LW(LEVEL_W)) u_tx_flags (
    .count (tx_cnt),
    .level (tx_lvl),
    .flags (tx_flags)
  );

  afi_level_flags #(.DEPTH(DEPTH), .CW(CNT_W), .LW(LEVEL_W)) u_rx_flags (
    .count (rx_cnt),
    .level (rx_lvl),
    .flags (rx_flags)
  );

  // interrupt sources, one per enable bit
  logic [SRC_N-1:0] src, status;
  logic             pending;

  assign src = {tx_pop_done | rx_push_done,
                tx_flags, tx_starve, tx_ovf,
                rx_flags, rx_starve, rx_ovf};

  afi_irq_unit #(.SRC_N(SRC_N)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (src),
    .src_en    (src_en),
    .global_en (glb_en),
    .clr       (irq_clr),
    .status    (status),
    .pending   (pending),
    .irq       (irq)
  );

  // shifter side and DMA requests
  assign tx_ser_data  = tx_head;
  assign tx_ser_valid = tx_en & ~tx_flags.empty;
  assign rx_ser_ready = rx_en & ~rx_flags.full;
  assign tx_dma_req   = tx_dma_en & tx_en & tx_flags.almost_empty;
  assign rx_dma_req   = rx_dma_en & rx_en & rx_flags.almost_full;

  // read mux, registered
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_CTRL: begin
        rd_mux[0] = tx_en;
        rd_mux[1] = rx_en;
        rd_mux[2] = tx_dma_en;
        rd_mux[3] = rx_dma_en;
        rd_mux[TXL_LSB +: LEVEL_W] = tx_lvl;
        rd_mux[RXL_LSB +: LEVEL_W] = rx_lvl;
      end
      REG_IRQ_EN: begin
        rd_mux[SRC_N-1:0] = src_en;
        rd_mux[GLB_BIT]   = glb_en;
      end
      REG_IRQ_STAT: begin
        rd_mux[SRC_N-1:0] = status;
        rd_mux[PND_BIT]   = pending;
      end
      REG_FIFO_STAT: rd_mux = {12'b0, 6'(tx_cnt), tx_flags, 6'(rx_cnt), rx_flags};
      REG_RX_DATA:   rd_mux = {{PAD_W{1'b0}}, rx_pop_done,
                               rx_pop_done ? rx_head : {SAMPLE_W{1'b0}}};
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  logic unused_bits;
  assign unused_bits = &{reg_wdata[31:19], tx_push_done};

  AST_TX_DMA_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> (int'(tx_cnt) <= int'(tx_lvl)));  // R11
  AST_RX_READY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ser_ready |-> (int'(rx_cnt) < DEPTH));  // R6
  AST_EMPTY_READ_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_cnt == '0) |=> !reg_rdata[SAMPLE_W]);  // R4

endmodule

// File: tb/afi_audio_fifo_test.sv
module afi_audio_fifo_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] tx_ser_data, rx_ser_data = '0;
  logic        tx_ser_valid, tx_ser_take = 1'b0, rx_ser_put = 1'b0, rx_ser_ready;
  logic        tx_dma_req, rx_dma_req, irq;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  afi_audio_fifo uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_ser_data(tx_ser_data), .tx_ser_valid(tx_ser_valid), .tx_ser_take(tx_ser_take),
    .rx_ser_data(rx_ser_data), .rx_ser_put(rx_ser_put), .rx_ser_ready(rx_ser_ready),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic take();
    tx_ser_take = 1'b1; @(negedge clk); tx_ser_take = 1'b0;
  endtask

  task automatic put(input logic [15:0] d);
    rx_ser_data = d; rx_ser_put = 1'b1; @(negedge clk); rx_ser_put = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
  endtask

  function automatic logic [31:0] cw(bit te, bit re, bit td, bit rdm, int tl, int rl);
    logic [31:0] v = '0;
    v[0] = te; v[1] = re; v[2] = td; v[3] = rdm;
    v[18:13] = 6'(tl); v[12:7] = 6'(rl);
    return v;
  endfunction

  function automatic logic [31:0] fstat(int tc, int tl, int rc, int rl);
    logic [31:0] v = '0;
    v[19:14] = 6'(tc); v[13] = (tc == 0); v[12] = (tc <= tl);
    v[11] = (tc == 32); v[10] = (tc + tl >= 32);
    v[9:4] = 6'(rc); v[3] = (rc == 0); v[2] = (rc <= rl);
    v[1] = (rc == 32); v[0] = (rc + rl >= 32);
    return v;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(3'd3, d); chk("R1 queue status", d, 32'h300C);
    rd(3'd2, d); chk("R1 irq status", d, 0);
    rd(3'd0, d); chk("R1 control", d, 0);
    rd(3'd1, d); chk("R1 irq enable", d, 0);
    chk("R1 outputs", {irq, tx_dma_req, rx_dma_req, tx_ser_valid}, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    do_reset();
    wr(3'd1, 32'h4000 | 32'hC3);
    wr(3'd4, 32'h1ABCD);
    put(16'h1234);
    take();
    rd(3'd5, d); chk("R8 disabled rx read", d, 0);
    idle(1);
    rd(3'd3, d); chk("R8 counts unchanged", d, 32'h300C);
    rd(3'd2, d); chk("R8 no error latched", d, 0);
    chk("R8 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_tx_order();
    logic [31:0] d;
    do_reset();
    wr(3'd0, cw(1, 0, 0, 0, 4, 0));
    for (int i = 0; i < 4; i++) wr(3'd4, 32'h10000 | (32'h100 + i));
    wr(3'd4, 32'h00BAD);
    rd(3'd3, d); chk("R3 invalid write dropped / R5 at level", d, fstat(4, 4, 0, 0));
    wr(3'd4, 32'h10104);
    rd(3'd3, d); chk("R5 above level", d, fstat(5, 4, 0, 0));
    wr(3'd1, 32'h1000);
    for (int i = 0; i < 5; i++) begin
      chk("R2 valid", {31'b0, tx_ser_valid}, 1);
      chk("R2 order", {16'b0, tx_ser_data}, 32'h100 + i);
      take();
    end
    chk("R2 drained", {31'b0, tx_ser_valid}, 0);
    idle(1);
    rd(3'd2, d); chk("R12 word moved", d, 32'h3000);
  endtask

  task automatic t_tx_full();
    logic [31:0] d;
    do_reset();
    wr(3'd0, cw(1, 0, 0, 0, 0, 0));
    wr(3'd1, 32'h4000 | 32'h00C0);
    for (int i = 0; i < 33; i++) wr(3'd4, 32'h10000 | i);
    idle(1);
    rd(3'd3, d); chk("R6 full count", d, fstat(32, 0, 0, 0));
    rd(3'd2, d); chk("R6 overflow latched", d, 32'h2040);
    chk("R9 irq raised", {31'b0, irq}, 1);
    wr(3'd6, 0);
    chk("R10 irq after clear", {31'b0, irq}, 0);
    idle(1);
    rd(3'd2, d); chk("R10 status cleared", d, 0);
    for (int i = 0; i < 32; i++) begin
      chk("R6 kept words", {16'b0, tx_ser_data}, i);
      take();
    end
    chk("R7 nothing valid", {31'b0, tx_ser_valid}, 0);
    take();
    idle(1);
    rd(3'd2, d); chk("R7 starve latched", d, 32'h2080);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    do_reset();
    wr(3'd0, cw(0, 1, 0, 1, 0, 8));
    wr(3'd1, 32'h0002);
    for (int i = 0; i < 23; i++) put(16'h2000 + 16'(i));
    chk("R11 rx req below", {31'b0, rx_dma_req}, 0);
    chk("R6 ready with room", {31'b0, rx_ser_ready}, 1);
    put(16'h2017);
    chk("R11 rx req at level", {31'b0, rx_dma_req}, 1);
    rd(3'd3, d); chk("R5 rx status", d, fstat(0, 0, 24, 8));
    for (int i = 0; i < 24; i++) begin
      rd(3'd5, d); chk("R4 rx data", d, 32'h10000 | (32'h2000 + i));
      if (i == 0) chk("R11 rx req drops", {31'b0, rx_dma_req}, 0);
    end
    rd(3'd5, d); chk("R4 empty read", d, 0);
    idle(1);
    rd(3'd2, d); chk("R4 rx starve latched", d, 32'h2002);
  endtask

  task automatic t_irq_level();
    logic [31:0] d;
    do_reset();
    wr(3'd1, 32'h0800);
    idle(1);
    rd(3'd2, d); chk("R9 empty latched, enabled only", d, 32'h2800);
    chk("R9 irq needs global", {31'b0, irq}, 0);
    wr(3'd1, 32'h4800);
    chk("R9 irq with global", {31'b0, irq}, 1);
    wr(3'd6, 0);
    rd(3'd2, d); chk("R10 cleared", d, 0);
    idle(1);
    rd(3'd2, d); chk("R10 level relatched", d, 32'h2800);
  endtask

  task automatic t_dma_tx();
    do_reset();
    wr(3'd0, cw(1, 0, 1, 0, 2, 0));
    chk("R11 tx req empty", {31'b0, tx_dma_req}, 1);
    for (int i = 0; i < 3; i++) wr(3'd4, 32'h10000 | i);
    chk("R11 tx req above level", {31'b0, tx_dma_req}, 0);
    take();
    chk("R11 tx req at level", {31'b0, tx_dma_req}, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(1);
    t_reset();
    t_disabled();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_irq_level();
    t_dma_tx();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule